// File: doc/BRIEF.md
# Serial Audio Transmitter with Underflow Handling

This block is the transmit side of a synchronous serial audio port. A DMA engine or CPU writes words into a holding register. At the start of each frame the holding register is copied into a shift register. The word then leaves on `txData`, most significant bit first, one bit per bit-clock period. The block always acts as clock master: it drives a continuous bit clock from a fixed divider of the system clock, and it drives a one-bit-wide frame-sync pulse that comes one bit period before the first data bit.

Frame timing has two modes. In rate mode a frame starts every `cfgFramePeriod` bit periods whether or not data is ready. If no new word arrived, the word left in the holding register is sent again. In copy-driven mode a frame starts only when the period has run out and a fresh word is waiting. Without fresh data, frame sync and output stop until software or DMA supplies a word.

A one-cycle `txReady` pulse marks every holding-to-shift copy, so the next word can be written. The active-low `emptyN` flag reports underflow: it is low after reset and after any word that finished shifting with nothing new written. It returns high when a freshly written word is copied.

Top module: `ser_tx_top`

## Requirements
- R1: While reset is held and right after it is released, `emptyN`, `frameSync`, `txData` and `txReady` are all 0.
- R2: `bitClk` runs in every mode, with a period of CLK_DIV system cycles. It is low for the first half of each bit period, which begins on the edge where serial outputs change, and high for the second half.
- R3: In rate mode (`cfgSyncFromCopy`=0), `frameSync` is high for exactly one bit period, every `cfgFramePeriod` bit periods, whether or not new data was written.
- R4: The word sits in the low W bits of `wrData`, where W is 8 for `cfgWordSel`=0, 16 for 1, and 32 for 2 or 3. It is sent MSB first in the W bit periods right after the frame-sync bit period. `txData` is 0 in every other bit period.
- R5: The holding register is copied into the shift register on the edge where `frameSync` rises. `txReady` is high for exactly one system cycle at each copy.
- R6: If no word was written since the previous copy, the next frame sends the old holding-register contents again.
- R7: `emptyN` falls to 0 at the end of the last data bit of a word if no new word has been written by then.
- R8: `emptyN` rises to 1 only on the edge where a freshly written word is copied into the shift register.
- R9: In copy-driven mode (`cfgSyncFromCopy`=1), a frame starts only when the frame period has elapsed (or the transmitter is idle) and a fresh word is held. Until then `frameSync`, `txData` and `txReady` stay 0.
- R10: A write in the same cycle as a copy does not affect that copy. The frame sends the earlier contents, and the new word is held as fresh for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWordSel | input | 2 | Word length select: 0=8, 1=16, 2 or 3=32 bits |
| cfgFramePeriod | input | FP_W | Frame length in bit periods (at least W+1) |
| cfgSyncFromCopy | input | 1 | 1 = frame sync comes from the data copy, 0 = from the rate counter |
| wrValid | input | 1 | Write strobe into the holding register |
| wrData | input | DATA_W | Word to send, right-aligned |
| bitClk | output | 1 | Bit clock |
| frameSync | output | 1 | Frame-sync pulse, one bit period wide |
| txData | output | 1 | Serial data, MSB first |
| txReady | output | 1 | One-cycle pulse per holding-to-shift copy |
| emptyN | output | 1 | Active-low underflow flag |

## Verification
A wrong internal state shows up in different places depending on where it sits:
- A slot counter that is off by one appears at the next bit-period boundary, as a frame-sync or data bit in the wrong period.
- A lost or stuck fresh marker appears within one frame: a stale word where a new one was expected, or, in copy-driven mode, a permanent stall with the bit clock still running.
- An empty flag that is mistimed appears on the exact edge where the last data bit ends.

The bench's reference model is compared against every output on every cycle, so each of these faults is reported on the cycle it first reaches a port.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  // Strobes from the frame control to the datapath, all single-cycle.
  typedef struct packed {
    logic copy;     // load shift register from holding register
    logic shift;    // present next data bit
    logic clear;    // drive serial data low
    logic endWord;  // last data bit period is ending
  } txStrobes_t;

  function automatic logic [5:0] wordBits(input logic [1:0] sel);
    case (sel)
      2'd0:    wordBits = 6'd8;
      2'd1:    wordBits = 6'd16;
      default: wordBits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int FP_W    = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgSyncFromCopy,
  input  logic [FP_W-1:0] cfgFramePeriod,
  input  logic [1:0]      cfgWordSel,
  input  logic            fresh,
  output txStrobes_t      st,
  output logic            bitClk,
  output logic            frameSync,
  output logic            txReady
);

  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_DIV / 2);

  logic [DIV_W-1:0] divCnt;
  logic [FP_W-1:0]  slot;
  logic [FP_W-1:0]  nextSlot;
  logic [FP_W-1:0]  wordLen;
  logic             active;
  logic             tick;
  logic             frameEnd;
  logic             startNow;
  logic             stallNow;
  logic             advance;

  assign tick     = (divCnt == DIV_LAST);
  assign wordLen  = FP_W'(wordBits(cfgWordSel));
  assign nextSlot = slot + 1'b1;
  assign frameEnd = !active || (slot == cfgFramePeriod - 1'b1);
  assign startNow = tick && frameEnd && (!cfgSyncFromCopy || fresh);
  assign stallNow = tick && frameEnd && !startNow;
  assign advance  = tick && !frameEnd;

  always_comb begin
    st.copy    = startNow;
    st.shift   = advance && (nextSlot <= wordLen);
    st.clear   = (advance && (nextSlot > wordLen)) || stallNow;
    st.endWord = tick && active && (slot == wordLen);
  end

  assign bitClk = (divCnt >= DIV_HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      slot      <= '0;
      active    <= 1'b0;
      frameSync <= 1'b0;
      txReady   <= 1'b0;
    end else begin
      divCnt  <= tick ? '0 : divCnt + 1'b1;
      txReady <= startNow;
      if (startNow) begin
        slot      <= '0;
        active    <= 1'b1;
        frameSync <= 1'b1;
      end else if (stallNow) begin
        active    <= 1'b0;
        frameSync <= 1'b0;
      end else if (advance) begin
        slot      <= nextSlot;
        frameSync <= 1'b0;
      end
    end
  end

  // R5: the ready request never lasts more than one cycle
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> !txReady);

  // R3: frame sync only rises on a bit-period boundary, with bit clock low
  p_sync_on_boundary_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSync) |-> !bitClk);

endmodule

// File: rtl/ser_tx_dp.sv
module ser_tx_dp
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        cfgWordSel,
  input  logic              cfgSyncFromCopy,
  input  txStrobes_t        st,
  output logic              fresh,
  output logic              txData,
  output logic              emptyN
);

  // DATA_W must be at least 32 so that every word length fits.
  localparam logic [5:0] FULL_W = 6'(DATA_W);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] aligned;
  logic [5:0]        wordLen;

  assign wordLen = wordBits(cfgWordSel);
  assign aligned = holdReg << (FULL_W - wordLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
      fresh    <= 1'b0;
      txData   <= 1'b0;
      emptyN   <= 1'b0;
    end else begin
      // a write lands after a same-cycle copy has taken the old contents
      if (wrValid) begin
        holdReg <= wrData;
        fresh   <= 1'b1;
      end else if (st.copy) begin
        fresh   <= 1'b0;
      end

      if (st.copy) begin
        shiftReg <= aligned;
        txData   <= 1'b0;
      end else if (st.shift) begin
        txData   <= shiftReg[DATA_W-1];
        shiftReg <= shiftReg << 1;
      end else if (st.clear) begin
        txData   <= 1'b0;
      end

      if (st.endWord && !fresh)
        emptyN <= 1'b0;
      else if (st.copy && fresh)
        emptyN <= 1'b1;
    end
  end

  // R9: copy-driven mode never starts a frame without a fresh word
  p_copy_needs_fresh_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSyncFromCopy && st.copy) |-> fresh);

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 32,
  parameter int FP_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgWordSel,
  input  logic [FP_W-1:0]   cfgFramePeriod,
  input  logic              cfgSyncFromCopy,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              bitClk,
  output logic              frameSync,
  output logic              txData,
  output logic              txReady,
  output logic              emptyN
);

  txStrobes_t strobes;
  logic       fresh;

  ser_tx_ctrl #(.CLK_DIV(CLK_DIV), .FP_W(FP_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cfgSyncFromCopy(cfgSyncFromCopy),
    .cfgFramePeriod (cfgFramePeriod),
    .cfgWordSel     (cfgWordSel),
    .fresh          (fresh),
    .st             (strobes),
    .bitClk         (bitClk),
    .frameSync      (frameSync),
    .txReady        (txReady)
  );

  ser_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .wrValid        (wrValid),
    .wrData         (wrData),
    .cfgWordSel     (cfgWordSel),
    .cfgSyncFromCopy(cfgSyncFromCopy),
    .st             (strobes),
    .fresh          (fresh),
    .txData         (txData),
    .emptyN         (emptyN)
  );

  // R4: no data bit is driven during the frame-sync bit period
  p_sync_data_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> !txData);

  // R8: empty clears only together with a copy
  p_empty_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyN) |-> txReady);

endmodule

// File: tb/ser_tx_top_bench.sv
module ser_tx_top_bench;

  localparam int CLK_DIV = 4;
  localparam int DATA_W  = 32;
  localparam int FP_W    = 8;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        cfgWordSel = 2'd1;
  logic [FP_W-1:0]   cfgFramePeriod = 8'd20;
  logic              cfgSyncFromCopy = 1'b0;
  logic              wrValid = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic bitClk, frameSync, txData, txReady, emptyN;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ser_tx_top #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W), .FP_W(FP_W)) u_ser_tx_top (
    .clk(clk), .rstN(rstN), .cfgWordSel(cfgWordSel), .cfgFramePeriod(cfgFramePeriod),
    .cfgSyncFromCopy(cfgSyncFromCopy), .wrValid(wrValid), .wrData(wrData),
    .bitClk(bitClk), .frameSync(frameSync), .txData(txData), .txReady(txReady),
    .emptyN(emptyN)
  );

  function automatic int wlen(input logic [1:0] sel);
    return (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : 32;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          mDiv, mSlot;
  bit          mActive, mFs, mData, mReady, mFresh, mEmptyN;
  logic [31:0] mShift, mHold;

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mSlot = 0; mActive = 0; mFs = 0; mData = 0; mReady = 0;
      mFresh = 0; mEmptyN = 0; mShift = '0; mHold = '0;
    end else begin
      bit tick, started, frameEnd;
      int wl;
      tick = (mDiv == CLK_DIV - 1);
      mDiv = tick ? 0 : mDiv + 1;
      mReady = 0;
      started = 0;
      if (tick) begin
        wl = wlen(cfgWordSel);
        if (mActive && mSlot == wl && !mFresh) mEmptyN = 0;
        frameEnd = !mActive || (mSlot == int'(cfgFramePeriod) - 1);
        if (frameEnd && (!cfgSyncFromCopy || mFresh)) begin
          started = 1; mSlot = 0; mActive = 1; mFs = 1; mData = 0; mReady = 1;
          mShift = mHold << (32 - wl);
          if (mFresh) mEmptyN = 1;
        end else if (frameEnd) begin
          mActive = 0; mFs = 0; mData = 0;
        end else begin
          mSlot++; mFs = 0;
          if (mSlot <= wl) begin mData = mShift[31]; mShift = mShift << 1; end
          else mData = 0;
        end
      end
      if (wrValid) begin mHold = wrData; mFresh = 1; end
      else if (started) mFresh = 0;
    end
  end

  // ---------------- per-cycle comparison and serial receiver ----------------
  logic [31:0] rxQ[$];
  logic [31:0] rxAcc;
  int  rxCnt = -1;
  bit  prevBclk = 0;
  int  syncRises = 0, readyCount = 0, bclkRises = 0;
  bit  prevFs = 0;

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(bitClk == (mDiv >= CLK_DIV / 2), "R2 bitClk", bitClk, (mDiv >= CLK_DIV / 2));
      check(frameSync == mFs, "R3 frameSync", frameSync, mFs);
      check(txData == mData, "R4 txData", txData, mData);
      check(txReady == mReady, "R5 txReady", txReady, mReady);
      check(emptyN == mEmptyN, "R7 emptyN", emptyN, mEmptyN);
      if (txReady) readyCount++;
      if (frameSync && !prevFs) syncRises++;
      if (bitClk && !prevBclk) begin
        bclkRises++;
        if (frameSync) begin rxCnt = 0; rxAcc = '0; end
        else if (rxCnt >= 0) begin
          rxAcc = {rxAcc[30:0], txData};
          rxCnt++;
          if (rxCnt == wlen(cfgWordSel)) begin rxQ.push_back(rxAcc); rxCnt = -1; end
        end
      end
    end
    prevBclk = bitClk;
    prevFs = frameSync;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic writeWord(input logic [31:0] w);
    wrData = w; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitReady();
    @(negedge clk);
    for (int i = 0; i < 4000 && !txReady; i++) @(negedge clk);
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] words16[5] = '{32'hA5C3, 32'h1234, 32'hFFFF, 32'h8001, 32'h0F0F};

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(emptyN == 0 && frameSync == 0 && txData == 0 && txReady == 0,
          "R1 reset outputs", {emptyN, frameSync, txData, txReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(emptyN == 0 && txReady == 0, "R1 after release", {emptyN, txReady}, 0);

    // R4/R5: rate mode streaming, 16-bit words
    writeWord(words16[0]);
    for (int k = 1; k < 5; k++) begin
      waitReady();
      writeWord(words16[k]);
    end
    waitReady();
    waitCycles(20 * CLK_DIV);
    check(rxQ.size() >= 5, "R4 words received", rxQ.size(), 5);
    for (int k = 0; k < 5 && k < rxQ.size(); k++)
      check(rxQ[k] == words16[k], "R4 streamed word", rxQ[k], words16[k]);

    // R6/R7: underflow repeats the last word, empty flag low
    rxQ.delete();
    syncRises = 0;
    waitCycles(3 * 20 * CLK_DIV);
    check(rxQ.size() >= 2, "R6 stale frames sent", rxQ.size(), 2);
    for (int k = 0; k < rxQ.size(); k++)
      check(rxQ[k] == words16[4], "R6 stale word", rxQ[k], words16[4]);
    check(syncRises >= 2, "R3 sync continues without data", syncRises, 3);
    check(emptyN == 0, "R7 empty during underflow", emptyN, 0);

    // R8: fresh word restores the flag at its copy
    writeWord(32'h5A5A);
    check(emptyN == 0, "R8 empty unchanged by write alone", emptyN, 0);
    waitReady();
    check(emptyN == 1, "R8 empty set at fresh copy", emptyN, 1);

    // R9: copy-driven mode stalls without data
    cfgSyncFromCopy = 1'b1;
    waitCycles(2);
    syncRises = 0; readyCount = 0; bclkRises = 0;
    waitCycles(10 * 20 * CLK_DIV);
    check(syncRises == 0, "R9 no frame sync while stalled", syncRises, 0);
    check(readyCount == 0, "R9 no request while stalled", readyCount, 0);
    check(txData == 0, "R9 data low while stalled", txData, 0);
    check(bclkRises >= 190, "R2 bit clock runs during stall", bclkRises, 200);
    rxQ.delete();
    writeWord(32'h00C3);
    waitReady();
    check(frameSync == 1, "R9 frame starts on fresh word", frameSync, 1);
    waitCycles(20 * CLK_DIV);
    check(rxQ.size() == 1 && rxQ[0] == 32'h00C3, "R9 word after stall",
          (rxQ.size() > 0) ? rxQ[0] : 0, 32'h00C3);

    // R10: write colliding with a copy in rate mode, 8-bit words
    cfgSyncFromCopy = 1'b0;
    cfgWordSel = 2'd0;
    cfgFramePeriod = 8'd12;
    waitReady();
    writeWord(32'h3C);
    waitReady();            // copy of 0x3C seen here
    rxQ.delete();
    waitCycles(12 * CLK_DIV - 1);
    writeWord(32'hE7);      // lands on the next copy edge
    waitReady();
    waitCycles(2 * 12 * CLK_DIV);
    check(rxQ.size() >= 3, "R10 frames received", rxQ.size(), 3);
    if (rxQ.size() >= 3) begin
      check(rxQ[0] == 32'h3C, "R10 first frame", rxQ[0], 32'h3C);
      check(rxQ[1] == 32'h3C, "R10 colliding copy keeps old word", rxQ[1], 32'h3C);
      check(rxQ[2] == 32'hE7, "R10 new word in next frame", rxQ[2], 32'hE7);
    end

    // R4: 32-bit words
    cfgWordSel = 2'd2;
    cfgFramePeriod = 8'd36;
    writeWord(32'hDEADBEEF);
    waitReady();
    writeWord(32'h80000001);
    waitReady();
    rxQ.delete();
    waitCycles(36 * CLK_DIV + 8);
    check(rxQ.size() >= 1 && rxQ[0] == 32'h80000001, "R4 32-bit word",
          (rxQ.size() > 0) ? rxQ[0] : 0, 32'h80000001);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule